// File: doc/BRIEF.md
# Masked Control Register Bank with Atomic Bit Aliases

This block is a 32-bit memory-mapped register file that holds clock and analog control words. Each base register owns a per-bit protect mask. A bit whose mask bit is 1 is held by the hardware. A bit whose mask bit is 0 can be written by software. Some base registers also answer at three neighbouring word addresses. A write to one of these aliases sets, clears or inverts selected bits in place, so software does not need a read-modify-write sequence.

Base register `k` sits at word index `4*k`. Its aliases, when present, sit at word indices `4*k+1` (set), `4*k+2` (clear) and `4*k+3` (toggle). A read at any alias returns the base register and changes nothing. At reset every register loads a fixed value. Registers flagged as PLL controls also have their lock bit forced high, so they report locked from the first cycle. The whole register contents are driven out in parallel so that downstream clock logic can decode the fields it needs.

Top module: `clkctl_regbank`

## Requirements
- R1: A write at slot 0 (byte address `16*k`) keeps every bit of register `k` whose mask bit is 1 and loads `wdata` into every bit whose mask bit is 0.
- R2: A write at slot 1 (byte address `16*k+4`) ORs into register `k` the `wdata` bits that its mask leaves unprotected.
- R3: A write at slot 2 (byte address `16*k+8`) clears in register `k` each bit that is 1 in `wdata` and not protected by the mask.
- R4: A write at slot 3 (byte address `16*k+12`) inverts in register `k` each bit that is 1 in `wdata` and not protected by the mask.
- R5: A read at any slot of register `k` returns the current value of register `k` and leaves every register unchanged.
- R6: After reset each register holds its fixed reset word. In PLL registers (indices 1 and 2 by default) bit 31, the lock bit, reads 1.
- R7: A register with an all-zero mask (index 0 and 5) takes any written word in full. A register with an all-ones mask (index 3) ignores writes.
- R8: A request is rejected when any of these holds: the base index is `NUM_BASE` or above, `addr[1:0]` is not 0, `be` is not `4'hF`, or the slot is non-zero on a register without aliases (indices 3, 4 and 7). A rejected request raises `err` for exactly one cycle, starting the cycle after the request. A rejected read returns 0 and a rejected write changes no register.
- R9: `rdata` and `rvalid` appear in the cycle after a read request, and `rvalid` stays low after writes. A write is visible on `regs_o` after the clock edge on which it was requested.
- R10: No write path ever changes a bit whose mask bit is 1. This holds for a PLL lock bit as well.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Byte address; word index is `addr[7:2]` |
| be | input | 4 | Byte enables; anything other than all ones is rejected |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rvalid | output | 1 | Read response strobe, one cycle after a read request |
| err | output | 1 | One-cycle pulse after a rejected request |
| regs_o | output | 256 | All register contents; register `k` at bits `[32*k+31:32*k]` |

## Verification
The hardest case to reach is a long run of mixed alias operations where a mask boundary falls in the middle of a field. In that case protected bits must survive set, clear and toggle writes that hit them repeatedly. A single directed write does not show this, because a bug may cancel out within one operation. The stimulus therefore drives an LFSR-driven sequence of several hundred plain and alias writes onto every register that has aliases, including the PLL registers with their masked lock bit. After each write it compares the whole register against a bench model. Error cases are placed right next to legal accesses, so that a rejected request that leaks a write or a read value shows up at once.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

  localparam int DATA_W  = 32;
  localparam int DEF_NUM = 8;

  // The slot number inside a 4-word group selects the operation.
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_FLIP  = 2'd3
  } op_e;

  // Register k is the k-th 32-bit lane, index 0 rightmost.
  localparam logic [DEF_NUM-1:0][DATA_W-1:0] DEF_MASK = {
    32'hC000_0000, 32'h00FF_0000, 32'h0000_0000, 32'hF000_00F0,
    32'hFFFF_FFFF, 32'h8000_F000, 32'h8000_0F00, 32'h0000_0000
  };

  localparam logic [DEF_NUM-1:0][DATA_W-1:0] DEF_RESET = {
    32'h0000_0012, 32'h0400_0000, 32'hFFFF_FFFF, 32'h0018_0D00,
    32'h0000_0010, 32'h0000_1005, 32'h0001_2003, 32'h0000_1234
  };

  localparam logic [DEF_NUM-1:0] DEF_ALIAS = 8'b0110_0111;
  localparam logic [DEF_NUM-1:0] DEF_PLL   = 8'b0000_0110;

  // Next value of a register for one write operation.
  function automatic logic [DATA_W-1:0] apply_op(
    input op_e               op,
    input logic [DATA_W-1:0] cur,
    input logic [DATA_W-1:0] data,
    input logic [DATA_W-1:0] mask
  );
    logic [DATA_W-1:0] open_bits;
    open_bits = data & ~mask;
    unique case (op)
      OP_WRITE: apply_op = (cur & mask) | open_bits;
      OP_SET:   apply_op = cur | open_bits;
      OP_CLEAR: apply_op = cur & ~open_bits;
      default:  apply_op = cur ^ open_bits;
    endcase
  endfunction

  // Reset word, with the lock bit forced for PLL registers.
  function automatic logic [DATA_W-1:0] reset_word(
    input logic [DATA_W-1:0] raw,
    input logic              is_pll,
    input int                lock_bit
  );
    logic [DATA_W-1:0] lock_m;
    lock_m = DATA_W'(1) << lock_bit;
    reset_word = is_pll ? (raw | lock_m) : raw;
  endfunction

endpackage

// File: rtl/clkctl_decode.sv
module clkctl_decode #(
  parameter int                 NUM_BASE  = 8,
  parameter int                 ADDR_W    = 8,
  parameter logic [NUM_BASE-1:0] HAS_ALIAS = '1,
  localparam int                BASE_W    = (NUM_BASE > 1) ? $clog2(NUM_BASE) : 1
) (
  input  logic                req,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [3:0]          be,
  output logic                acc_ok,
  output logic                acc_bad,
  output clkctl_pkg::op_e     op,
  output logic [BASE_W-1:0]   base_sel,
  output logic [NUM_BASE-1:0] wr_vec
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] word_idx;
  logic [IDX_W-1:0] base_full;
  logic [1:0]       slot;
  logic             in_range;
  logic             alias_ok;
  logic             aligned;
  logic             full_be;

  always_comb begin
    word_idx  = addr[ADDR_W-1:2];
    base_full = word_idx >> 2;
    slot      = word_idx[1:0];
    base_sel  = base_full[BASE_W-1:0];
    in_range  = base_full < IDX_W'(NUM_BASE);
    alias_ok  = (slot == 2'd0) || (in_range && HAS_ALIAS[base_sel]);
    aligned   = (addr[1:0] == 2'b00);
    full_be   = &be;
    op        = clkctl_pkg::op_e'(slot);
    acc_ok    = req && in_range && alias_ok && aligned && full_be;
    acc_bad   = req && !(in_range && alias_ok && aligned && full_be);
  end

  for (genvar k = 0; k < NUM_BASE; k++) begin : g_wr
    assign wr_vec[k] = acc_ok && we && (base_full == IDX_W'(k));
  end

endmodule

// File: rtl/clkctl_cell.sv
module clkctl_cell #(
  parameter logic [31:0] MASK     = 32'h0,
  parameter logic [31:0] RST_WORD = 32'h0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  clkctl_pkg::op_e op,
  input  logic [31:0]     wdata,
  output logic [31:0]     q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RST_WORD;
    end else if (wr_en) begin
      q <= clkctl_pkg::apply_op(op, q, wdata, MASK);
    end
  end
endmodule

// File: rtl/clkctl_resp.sv
module clkctl_resp #(
  parameter int  NUM_BASE = 8,
  localparam int BASE_W   = (NUM_BASE > 1) ? $clog2(NUM_BASE) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd_req,
  input  logic                   acc_ok,
  input  logic                   acc_bad,
  input  logic [BASE_W-1:0]      base_sel,
  input  logic [NUM_BASE*32-1:0] regs_flat,
  output logic [31:0]            rdata,
  output logic                   rvalid,
  output logic                   err
);
  logic [31:0] sel_word;

  always_comb begin
    sel_word = regs_flat[32*base_sel +: 32];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
      err    <= 1'b0;
    end else begin
      rvalid <= rd_req;
      err    <= acc_bad;
      rdata  <= (rd_req && acc_ok) ? sel_word : 32'h0;
    end
  end
endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank #(
  parameter int                              NUM_BASE = clkctl_pkg::DEF_NUM,
  parameter int                              ADDR_W   = 8,
  parameter int                              LOCK_BIT = 31,
  parameter logic [NUM_BASE-1:0][31:0]       P_MASK   = clkctl_pkg::DEF_MASK,
  parameter logic [NUM_BASE-1:0][31:0]       P_RESET  = clkctl_pkg::DEF_RESET,
  parameter logic [NUM_BASE-1:0]             P_ALIAS  = clkctl_pkg::DEF_ALIAS,
  parameter logic [NUM_BASE-1:0]             P_PLL    = clkctl_pkg::DEF_PLL
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req,
  input  logic                   we,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [3:0]             be,
  input  logic [31:0]            wdata,
  output logic [31:0]            rdata,
  output logic                   rvalid,
  output logic                   err,
  output logic [NUM_BASE*32-1:0] regs_o
);
  localparam int BASE_W = (NUM_BASE > 1) ? $clog2(NUM_BASE) : 1;

  // Named internal events, also observed by the bound checker.
  logic                acc_ok;
  logic                acc_bad;
  logic                rd_req;
  clkctl_pkg::op_e     op;
  logic [BASE_W-1:0]   base_sel;
  logic [NUM_BASE-1:0] wr_vec;

  assign rd_req = req && !we;

  clkctl_decode #(
    .NUM_BASE  (NUM_BASE),
    .ADDR_W    (ADDR_W),
    .HAS_ALIAS (P_ALIAS)
  ) u_decode (
    .req      (req),
    .we       (we),
    .addr     (addr),
    .be       (be),
    .acc_ok   (acc_ok),
    .acc_bad  (acc_bad),
    .op       (op),
    .base_sel (base_sel),
    .wr_vec   (wr_vec)
  );

  for (genvar k = 0; k < NUM_BASE; k++) begin : g_cell
    clkctl_cell #(
      .MASK     (P_MASK[k]),
      .RST_WORD (clkctl_pkg::reset_word(P_RESET[k], P_PLL[k], LOCK_BIT))
    ) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_vec[k]),
      .op    (op),
      .wdata (wdata),
      .q     (regs_o[32*k +: 32])
    );
  end

  clkctl_resp #(
    .NUM_BASE (NUM_BASE)
  ) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .acc_ok    (acc_ok),
    .acc_bad   (acc_bad),
    .base_sel  (base_sel),
    .regs_flat (regs_o),
    .rdata     (rdata),
    .rvalid    (rvalid),
    .err       (err)
  );

endmodule

// File: rtl/clkctl_regbank_chk.sv
module clkctl_regbank_chk #(
  parameter int                   NUM_BASE  = 8,
  parameter logic [NUM_BASE*32-1:0] MASK_FLAT = '0
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req,
  input logic                   we,
  input logic [31:0]            rdata,
  input logic                   rvalid,
  input logic                   err,
  input logic [NUM_BASE*32-1:0] regs_o,
  input logic                   acc_bad,
  input logic [NUM_BASE-1:0]    wr_vec
);
  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_vec)); // R1

  AST_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we) |=> $stable(regs_o)); // R5

  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_bad |=> err); // R8

  AST_ERR_ONLY_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_bad |=> !err); // R8

  AST_BAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_bad |=> $stable(regs_o)); // R8

  AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_bad && !we) |=> (rdata == 32'h0)); // R8

  AST_RD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we) |=> rvalid); // R9

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && !we) |=> !rvalid); // R9

  AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(regs_o & MASK_FLAT)); // R10

endmodule

bind clkctl_regbank clkctl_regbank_chk #(
  .NUM_BASE  (NUM_BASE),
  .MASK_FLAT (P_MASK)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .req     (req),
  .we      (we),
  .rdata   (rdata),
  .rvalid  (rvalid),
  .err     (err),
  .regs_o  (regs_o),
  .acc_bad (acc_bad),
  .wr_vec  (wr_vec)
);

// File: tb/clkctl_regbank_tb.sv
module clkctl_regbank_tb;
  localparam int NB = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [7:0]    addr = '0;
  logic [3:0]    be = 4'hF;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          rvalid;
  logic          err;
  logic [NB*32-1:0] regs_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] msk [NB];
  logic [31:0] mdl [NB];
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #5 clk = ~clk;

  clkctl_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .be(be),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .err(err), .regs_o(regs_o)
  );

  task automatic check(input string req_tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req_tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] reg_of(input int k);
    return regs_o[32*k +: 32];
  endfunction

  // One request cycle; outputs sampled at the next falling edge.
  task automatic access(input bit w, input logic [7:0] a, input logic [3:0] b,
                        input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; be = b; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; be = 4'hF;
  endtask

  // Bench model of one legal write, written differently from the rule text.
  function automatic logic [31:0] model_op(input int slot, input logic [31:0] c,
                                           input logic [31:0] d, input logic [31:0] m);
    case (slot)
      0: return c ^ ((c ^ d) & ~m);
      1: return c | (d & ~m);
      2: return c & (~d | m);
      default: return (c & m) | ((c ^ d) & ~m);
    endcase
  endfunction

  task automatic wr_model(input int k, input int slot, input logic [31:0] d,
                          input string tag);
    access(1'b1, 8'(16*k + 4*slot), 4'hF, d);
    mdl[k] = model_op(slot, mdl[k], d, msk[k]);
    check(tag, $sformatf("reg%0d slot%0d", k, slot), reg_of(k), mdl[k]);
  endtask

  task automatic t_reset;
    check("R6", "reg0 reset", reg_of(0), 32'h0000_1234);
    check("R6", "reg1 reset lock", reg_of(1), 32'h8001_2003);
    check("R6", "reg2 reset lock", reg_of(2), 32'h8000_1005);
    check("R6", "reg3 reset", reg_of(3), 32'h0000_0010);
    check("R6", "reg4 reset", reg_of(4), 32'h0018_0D00);
    check("R6", "reg5 reset", reg_of(5), 32'hFFFF_FFFF);
    check("R6", "reg6 reset", reg_of(6), 32'h0400_0000);
    check("R6", "reg7 reset", reg_of(7), 32'h0000_0012);
    check("R9", "rvalid after reset", {31'h0, rvalid}, 32'h0);
    check("R8", "err after reset", {31'h0, err}, 32'h0);
  endtask

  task automatic t_plain;
    wr_model(0, 0, 32'hDEAD_BEEF, "R7");
    check("R7", "reg0 full write", reg_of(0), 32'hDEAD_BEEF);
    wr_model(5, 0, 32'h0000_0000, "R7");
    wr_model(4, 0, 32'hFFFF_FFFF, "R1");
    check("R1", "reg4 merged", reg_of(4), 32'h0FFF_FF0F);
    access(1'b1, 8'h30, 4'hF, 32'hA5A5_A5A5);
    check("R7", "reg3 write ignored", reg_of(3), 32'h0000_0010);
    wr_model(1, 0, 32'h0000_0000, "R10");
    check("R10", "reg1 lock kept", reg_of(1), 32'h8000_0000);
    check("R9", "no rvalid on write", {31'h0, rvalid}, 32'h0);
  endtask

  task automatic t_alias_ops;
    wr_model(6, 1, 32'hFFFF_FFFF, "R2");
    check("R2", "reg6 set", reg_of(6), 32'hFF00_FFFF);
    wr_model(6, 2, 32'h0F0F_0F0F, "R3");
    check("R3", "reg6 clear", reg_of(6), 32'hF000_F0F0);
    wr_model(6, 3, 32'hFFFF_FFFF, "R4");
    check("R4", "reg6 toggle", reg_of(6), 32'h0F00_0F0F);
    wr_model(2, 2, 32'hFFFF_FFFF, "R10");
    check("R10", "reg2 clear keeps lock", reg_of(2), 32'h8000_1000);
    wr_model(2, 3, 32'h8000_0001, "R4");
  endtask

  task automatic t_alias_read;
    for (int s = 0; s < 4; s++) begin
      access(1'b0, 8'(16*1 + 4*s), 4'hF, 32'h0);
      check("R5", $sformatf("read slot%0d", s), rdata, mdl[1]);
      check("R9", "rvalid on read", {31'h0, rvalid}, 32'h1);
      check("R5", "no side effect", reg_of(1), mdl[1]);
    end
    @(negedge clk);
    check("R9", "rvalid one cycle", {31'h0, rvalid}, 32'h0);
  endtask

  task automatic t_errors;
    access(1'b0, 8'h80, 4'hF, 32'h0);
    check("R8", "oob read err", {31'h0, err}, 32'h1);
    check("R8", "oob read zero", rdata, 32'h0);
    access(1'b1, 8'h44, 4'hF, 32'hFFFF_FFFF);
    check("R8", "alias on plain-only reg err", {31'h0, err}, 32'h1);
    check("R8", "reg4 untouched", reg_of(4), mdl[4]);
    access(1'b1, 8'h01, 4'hF, 32'h1111_1111);
    check("R8", "misaligned err", {31'h0, err}, 32'h1);
    check("R8", "reg0 untouched", reg_of(0), mdl[0]);
    access(1'b1, 8'h00, 4'h7, 32'h2222_2222);
    check("R8", "partial be err", {31'h0, err}, 32'h1);
    check("R8", "reg0 untouched 2", reg_of(0), mdl[0]);
    access(1'b0, 8'h34, 4'hF, 32'h0);
    check("R8", "alias read reg3 zero", rdata, 32'h0);
    @(negedge clk);
    check("R8", "err one cycle", {31'h0, err}, 32'h0);
    access(1'b0, 8'h00, 4'hF, 32'h0);
    check("R8", "good access no err", {31'h0, err}, 32'h0);
    check("R5", "reg0 read", rdata, mdl[0]);
  endtask

  task automatic t_mixed;
    int alias_regs [5] = '{0, 1, 2, 5, 6};
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      wr_model(alias_regs[lfsr[2:0] % 5], int'(lfsr[5:4]), lfsr ^ {lfsr[15:0], lfsr[31:16]},
               (lfsr[5:4] == 2'd0) ? "R1" : (lfsr[5:4] == 2'd1) ? "R2" :
               (lfsr[5:4] == 2'd2) ? "R3" : "R4");
    end
    for (int k = 0; k < NB; k++)
      check("R10", $sformatf("reg%0d final", k), reg_of(k), mdl[k]);
  endtask

  initial begin
    msk = '{32'h0, 32'h8000_0F00, 32'h8000_F000, 32'hFFFF_FFFF,
            32'hF000_00F0, 32'h0, 32'h00FF_0000, 32'hC000_0000};
    mdl = '{32'h0000_1234, 32'h8001_2003, 32'h8000_1005, 32'h0000_0010,
            32'h0018_0D00, 32'hFFFF_FFFF, 32'h0400_0000, 32'h0000_0012};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_alias_ops();
    t_alias_read();
    t_errors();
    t_mixed();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule